// File: doc/BRIEF.md
# Receive FIFO Frame Readout Formatter

This block holds byte frames captured from a serial peripheral's input line. Each frame is tagged with the channel it came from and with its length. The block serves those frames to a host through one byte-wide read port. Every read burst opens with two header bytes that the block generates itself. The host asks for a burst of N bytes, and N counts those two header bytes. The first header byte says whether this burst starts a frame or continues one, and it carries the channel. The second header byte gives how many data bytes of the frame are still unread. This lets the host drain one frame over several short bursts.

Captured bytes arrive on a valid/ready stream. The block never stalls this stream: `in_ready` stays high once reset is released. A frame that does not fit is discarded as a whole, and a sticky overflow flag records the loss. Read bursts leave on a second valid/ready stream. Here the block holds `out_valid` and `out_data` steady while `out_ready` is low, so the consumer may stall any byte for any number of cycles. A burst request is taken only while `rd_req_ready` is high, which means no burst is in progress. Two status outputs feed host-side status registers: the number of stored frames, and the unread length of the oldest frame.

Top module: `rxr_readout`

## Requirements
- R1: Header byte 0 of a burst is built as follows.
  - Bit 7 is 0 when no data byte of the oldest frame has been read yet, and 1 otherwise.
  - Bits 6:0 hold the frame's channel, zero-extended. For example, channel 2 gives 0x02 on a start burst and 0x82 on a continuation.
  - A burst emits header byte 0 first, then header byte 1, then data bytes in capture order.
- R2: Header byte 1 equals the number of data bytes of the oldest frame still unread when the burst is accepted.
- R3: A burst emits exactly `rd_req_len` bytes, headers included. A length of 0 emits nothing. Data bytes left unread stay for the next burst, and a length of 1 or 2 consumes no data byte.
- R4: The frame is removed once its last data byte has been read. `frame_count` then drops by one, and the next burst carries a start header for the following frame.
- R5: Bytes requested past the end of the current frame within a burst read 0x00. They never take data from the next frame.
- R6: A burst accepted while no frame is stored emits only 0x00 bytes.
- R7: `frame_count` gives the number of fully captured frames held, and it includes a partly read one. A frame still being captured is not counted.
- R8: `next_len` gives the unread data bytes of the oldest frame, or 0 when none is stored.
- R9: A frame is kept only if all stored data bytes plus the new frame fit within 64 bytes and fewer than 4 frames are held. Otherwise the frame is dropped, `overflow` is set and stays set until reset, and the frames already stored are unchanged.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. An accepted non-empty request raises `out_valid` on the next cycle.
- R11: After reset, `frame_count`, `next_len`, `overflow` and `out_valid` are 0. `in_ready` is high from the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Captured byte valid |
| in_ready | output | 1 | Capture stream ready (high after reset) |
| in_data | input | 8 | Captured byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_chan | input | 3 | Channel tag, sampled with the last byte |
| rd_req_valid | input | 1 | Burst request valid |
| rd_req_ready | output | 1 | Burst request accepted (idle) |
| rd_req_len | input | 8 | Burst length in bytes, headers included |
| out_valid | output | 1 | Readout byte valid |
| out_ready | input | 1 | Readout consumer ready |
| out_data | output | 8 | Readout byte |
| frame_count | output | 3 | Number of stored frames |
| next_len | output | 7 | Unread data bytes of the oldest frame |
| overflow | output | 1 | Sticky frame-dropped flag |

## Verification
Some rules are checked by the assertions on every cycle:
- the readout stream holds its byte under back-pressure;
- an accepted request starts output on the next cycle;
- the overflow flag stays set once raised;
- the frame count stays within the descriptor depth;
- `next_len` is zero exactly when no frame is stored;
- `in_ready` is high after reset.

The bench's scenarios are needed for the rest. These cover the header contents across start and continuation bursts, and a frame drained in pieces. They also cover zero padding at a frame's end without spilling into the next frame, and empty-queue bursts. Finally, they cover both overflow causes (byte space and descriptor slots), each checked against a byte-level model.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_SEND = 1'b1
  } rd_state_e;

  localparam logic [7:0] CONT_BIT = 8'h80;
endpackage

// File: rtl/rxr_byte_ring.sv
module rxr_byte_ring #(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       commit,
  input  logic       drop,
  input  logic       rd_adv,
  output logic [7:0] rd_data,
  output logic       room
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wptr, cptr, rptr, wptr_nx;

  assign wptr_nx = wptr + PW'(wr_en);
  assign room    = (wptr - rptr) != PW'(DEPTH);
  assign rd_data = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      cptr <= '0;
      rptr <= '0;
    end else begin
      if (drop) wptr <= cptr;
      else      wptr <= wptr_nx;
      if (commit) cptr <= wptr_nx;
      if (rd_adv) rptr <= rptr + PW'(1);
    end
  end
endmodule

// File: rtl/rxr_desc_fifo.sv
module rxr_desc_fifo #(
  parameter int DQ = 4,
  parameter int CW = 3,
  parameter int LW = 7,
  localparam int QA = $clog2(DQ),
  localparam int FCW = $clog2(DQ + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [CW-1:0]  push_chan,
  input  logic [LW-1:0]  push_len,
  input  logic           pop,
  output logic           head_vld,
  output logic [CW-1:0]  head_chan,
  output logic [LW-1:0]  head_len,
  output logic [FCW-1:0] count,
  output logic           full
);
  logic [CW-1:0] chan_a [DQ];
  logic [LW-1:0] len_a  [DQ];
  logic [QA-1:0] wp, rp;

  assign head_vld  = count != '0;
  assign head_chan = chan_a[rp];
  assign head_len  = len_a[rp];
  assign full      = count == FCW'(DQ);

  always_ff @(posedge clk) begin
    if (push) begin
      chan_a[wp] <= push_chan;
      len_a[wp]  <= push_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + QA'(1);
      if (pop)  rp <= rp + QA'(1);
      count <= count + FCW'(push) - FCW'(pop);
    end
  end
endmodule

// File: rtl/rxr_burst_seq.sv
module rxr_burst_seq
  import rxr_pkg::*;
#(
  parameter int CW  = 3,
  parameter int LW  = 7,
  parameter int BLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [BLW-1:0] req_len,
  output logic           req_ready,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_data,
  input  logic           head_vld,
  input  logic [CW-1:0]  head_chan,
  input  logic [LW-1:0]  head_len,
  input  logic [7:0]     byte_in,
  output logic           take,
  output logic           pop,
  output logic [LW-1:0]  rem
);
  rd_state_e      st;
  logic [BLW-1:0] left;
  logic [1:0]     pos;
  logic           has_q, ended_q;
  logic [7:0]     hdr0_q, hdr1_q;
  logic [LW-1:0]  used;
  logic           serving, fire, accept;

  assign rem       = head_vld ? head_len - used : '0;
  assign req_ready = st == RD_IDLE;
  assign out_valid = st == RD_SEND;
  assign accept    = req_ready && req_valid && req_len != '0;
  assign serving   = out_valid && pos == 2'd2 && has_q && !ended_q;
  assign fire      = out_valid && out_ready;
  assign take      = fire && serving;
  assign pop       = take && rem == LW'(1);

  always_comb begin
    unique case (pos)
      2'd0:    out_data = hdr0_q;
      2'd1:    out_data = hdr1_q;
      default: out_data = serving ? byte_in : 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= RD_IDLE;
      left    <= '0;
      pos     <= '0;
      has_q   <= 1'b0;
      ended_q <= 1'b0;
      hdr0_q  <= '0;
      hdr1_q  <= '0;
      used    <= '0;
    end else begin
      if (accept) begin
        st      <= RD_SEND;
        left    <= req_len;
        pos     <= 2'd0;
        has_q   <= head_vld;
        ended_q <= 1'b0;
        hdr0_q  <= head_vld ? ((used != '0 ? CONT_BIT : 8'h00) | 8'(head_chan)) : 8'h00;
        hdr1_q  <= 8'(rem);
      end
      if (fire) begin
        left <= left - BLW'(1);
        if (left == BLW'(1)) st <= RD_IDLE;
        if (pos != 2'd2) pos <= pos + 2'd1;
      end
      if (take) begin
        if (pop) begin
          used    <= '0;
          ended_q <= 1'b1;
        end else begin
          used <= used + LW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rxr_readout.sv
module rxr_readout #(
  parameter int DEPTH = 64,
  parameter int DQ    = 4,
  parameter int CW    = 3,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int FCW  = $clog2(DQ + 1),
  localparam int BLW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_data,
  input  logic           in_last,
  input  logic [CW-1:0]  in_chan,
  input  logic           rd_req_valid,
  output logic           rd_req_ready,
  input  logic [BLW-1:0] rd_req_len,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_data,
  output logic [FCW-1:0] frame_count,
  output logic [LW-1:0]  next_len,
  output logic           overflow
);
  logic          room, dfull, acc, bad_q, bad_now, wr_en, last_acc, keep, drop;
  logic [LW-1:0] cur_len;
  logic          head_vld, take, pop;
  logic [CW-1:0] head_chan;
  logic [LW-1:0] head_len;
  logic [7:0]    ring_byte;

  assign acc      = in_valid && in_ready;
  assign bad_now  = bad_q || !room;
  assign wr_en    = acc && !bad_now;
  assign last_acc = acc && in_last;
  assign keep     = last_acc && !bad_now && !dfull;
  assign drop     = last_acc && !keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      bad_q    <= 1'b0;
      cur_len  <= '0;
      overflow <= 1'b0;
    end else begin
      in_ready <= 1'b1;
      if (drop) overflow <= 1'b1;
      if (last_acc) begin
        bad_q   <= 1'b0;
        cur_len <= '0;
      end else if (acc) begin
        bad_q <= bad_now;
        if (!bad_now) cur_len <= cur_len + LW'(1);
      end
    end
  end

  rxr_byte_ring #(.DEPTH(DEPTH)) u_ring (
    .clk, .rst_n,
    .wr_en, .wr_data(in_data),
    .commit(keep), .drop,
    .rd_adv(take), .rd_data(ring_byte),
    .room
  );

  rxr_desc_fifo #(.DQ(DQ), .CW(CW), .LW(LW)) u_desc (
    .clk, .rst_n,
    .push(keep), .push_chan(in_chan), .push_len(cur_len + LW'(1)),
    .pop, .head_vld, .head_chan, .head_len,
    .count(frame_count), .full(dfull)
  );

  rxr_burst_seq #(.CW(CW), .LW(LW), .BLW(BLW)) u_seq (
    .clk, .rst_n,
    .req_valid(rd_req_valid), .req_len(rd_req_len), .req_ready(rd_req_ready),
    .out_valid, .out_ready, .out_data,
    .head_vld, .head_chan, .head_len,
    .byte_in(ring_byte), .take, .pop, .rem(next_len)
  );
endmodule

// File: rtl/rxr_readout_chk.sv
module rxr_readout_chk #(
  parameter int DQ  = 4,
  parameter int FCW = 3,
  parameter int LW  = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           rd_req_valid,
  input logic           rd_req_ready,
  input logic [7:0]     rd_req_len,
  input logic           out_valid,
  input logic           out_ready,
  input logic [7:0]     out_data,
  input logic [FCW-1:0] frame_count,
  input logic [LW-1:0]  next_len,
  input logic           overflow
);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready && rd_req_len != 8'd0 |=> out_valid);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_count <= FCW'(DQ));

  // R8
  empty_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_count == '0 |-> next_len == '0);

  // R8
  held_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_count != '0 |-> next_len != '0);

  // R11
  in_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> in_ready);
endmodule

bind rxr_readout rxr_readout_chk #(.DQ(DQ), .FCW(FCW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_len(rd_req_len),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .frame_count(frame_count), .next_len(next_len), .overflow(overflow)
);

// File: tb/sim_rxr_readout.sv
`timescale 1ns/1ps
module sim_rxr_readout;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic [2:0] in_chan = '0;
  logic       rd_req_valid = 1'b0, rd_req_ready;
  logic [7:0] rd_req_len = '0;
  logic       out_valid, out_ready = 1'b1;
  logic [7:0] out_data;
  logic [2:0] frame_count;
  logic [6:0] next_len;
  logic       overflow;
  logic       bp_en = 1'b0;

  int total = 0, bad = 0;

  byte unsigned exp_q[$];
  string        tag_q[$];

  byte unsigned mdl_bytes[$];
  int           mdl_len[$];
  int           mdl_ch[$];
  int           mdl_used = 0;
  bit           mdl_ovf = 1'b0;

  always #5 clk = ~clk;

  rxr_readout u0 (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_last, .in_chan,
    .rd_req_valid, .rd_req_ready, .rd_req_len,
    .out_valid, .out_ready, .out_data,
    .frame_count, .next_len, .overflow
  );

  task automatic chk(int act, int exp, string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // readout back-pressure (R10)
  initial forever begin
    @(posedge clk);
    #1;
    out_ready <= bp_en ? ($urandom % 3 != 0) : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R3: actual=extra byte 0x%0h expected=none", out_data);
      end else begin
        chk(out_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic send_frame(int ch, int n, int base);
    int stored = mdl_bytes.size();
    bit fits = (stored + n <= 64) && (mdl_len.size() < 4);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(base + i);
      in_last  = (i == n - 1);
      in_chan  = 3'(ch);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (fits) begin
      for (int i = 0; i < n; i++) mdl_bytes.push_back(8'(base + i));
      mdl_len.push_back(n);
      mdl_ch.push_back(ch);
    end else begin
      mdl_ovf = 1'b1;
    end
  endtask

  task automatic burst(int n);
    bit has = mdl_len.size() > 0;
    bit ended = 1'b0;
    byte unsigned h0 = 0, h1 = 0;
    if (has) begin
      h0 = 8'((mdl_used != 0 ? 8'h80 : 8'h00) | mdl_ch[0]);
      h1 = 8'(mdl_len[0] - mdl_used);
    end
    for (int i = 0; i < n; i++) begin
      if (i == 0) begin exp_q.push_back(h0); tag_q.push_back("R1 header0"); end
      else if (i == 1) begin exp_q.push_back(h1); tag_q.push_back("R2 header1"); end
      else if (has && !ended) begin
        exp_q.push_back(mdl_bytes.pop_front());
        tag_q.push_back("R3 data");
        mdl_used++;
        if (mdl_used == mdl_len[0]) begin
          void'(mdl_len.pop_front());
          void'(mdl_ch.pop_front());
          mdl_used = 0;
          ended = 1'b1;
        end
      end else begin
        exp_q.push_back(8'h00);
        tag_q.push_back(has ? "R5 pad" : "R6 empty");
      end
    end
    @(negedge clk);
    while (!rd_req_ready) @(negedge clk);
    rd_req_valid = 1'b1;
    rd_req_len   = 8'(n);
    @(negedge clk);
    rd_req_valid = 1'b0;
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
    chk(exp_q.size(), 0, "R3 burst length");
  endtask

  task automatic status(string tag);
    @(negedge clk);
    chk(frame_count, mdl_len.size(), {tag, " R7 frame_count"});
    chk(next_len, mdl_len.size() ? mdl_len[0] - mdl_used : 0, {tag, " R8 next_len"});
    chk(overflow, mdl_ovf, {tag, " R9 overflow"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(frame_count, 0, "R11 count");
    chk(next_len, 0, "R11 next_len");
    chk(overflow, 0, "R11 overflow");
    chk(out_valid, 0, "R11 out_valid");
    chk(in_ready, 1, "R11 in_ready");

    burst(4);                       // R6 empty queue
    bp_en = 1'b1;

    send_frame(2, 10, 8'h01);
    status("R7 after capture");
    burst(8);                       // R1 start header 0x02, R2 = 10
    status("R8 partial");
    burst(6);                       // R1 continuation 0x82, R4 pop
    status("R4 drained");

    send_frame(1, 3, 8'hA0);
    send_frame(5, 4, 8'hB0);
    burst(7);                       // R5 pad, no spill into next frame
    status("R4 next frame");
    burst(1);                       // R3 header only
    burst(2);                       // R3 headers only, still start
    status("R3 no data consumed");
    burst(0);                       // R3 zero length
    burst(6);
    status("R4 empty again");

    send_frame(3, 64, 8'h40);       // exactly fills
    status("R9 full fit");
    send_frame(4, 1, 8'hEE);        // R9 byte space overflow
    status("R9 dropped");
    burst(66);
    status("R9 drained");

    for (int k = 0; k < 5; k++) send_frame(k, 2, 8'h10 * k);  // R9 slot overflow
    status("R9 slots");
    for (int k = 0; k < 4; k++) burst(5);
    status("R9 final");

    bp_en = 1'b0;
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule